// File: doc/BRIEF.md
# One-Time Lock Sequencer for a Protected Memory Region

This block is the command state machine that guards a small, one-time-lockable region inside a flash-style memory model. It receives qualified write strobes (address and data byte) and read strobes. When a digital "elevated reset" level is present and a settling delay has run out, it accepts a two-write protect sequence. It then sets a lock bit that nothing but power-on reset clears.

While the protect sequence is active, a read of the status address returns the lock state as a byte. A reset command, or a two-write exit pair, returns the machine from verify mode to normal read mode. In read mode the block passes region writes through to the region storage as a write enable, and it blocks them for good once the lock is set. The block does not model program timing, the analog voltage qualification or the array contents.

Top module: `seclock_seq`

## Requirements
- R1: After rst_ni is asserted, locked_o is 0, prot_mode_o is 0 (read mode) and rdata_valid_o is 0.
- R2: While elevated_i is high in read mode, the machine enters a settle phase that lasts SETTLE_CYC cycles, and prot_mode_o goes high. Writes during the settle phase are ignored, so a later 40h write still finds the setup step missing.
- R3: After the settle phase, a write of 60h to any address followed by a write of 40h to the status address sets the lock. The status address lies inside the region (addr_i[AW-1:SEC_LG] equal to the base) with addr_i[6]=0, addr_i[1]=1 and addr_i[0]=0. locked_o is 0 while the 40h write is presented and 1 from the clock after it is accepted.
- R4: A read of the status address after the 60h step, or in verify mode, returns 01h when locked and 00h when unlocked. Every other read returns 00h.
- R5: A write that is not the expected next step (not 60h at setup, or not 40h at the status address at the lock step) returns the machine to read mode and leaves the lock bit unchanged.
- R6: If elevated_i falls during the settle phase, the setup step or the lock step, the sequence aborts to read mode. In verify mode a fall of elevated_i has no effect.
- R7: Once set, locked_o stays 1 through every later command, sequence and write until rst_ni.
- R8: In read mode, a write whose address lies inside the region raises sec_we_o in the same cycle only while unlocked. After locking, such writes are ignored.
- R9: In verify mode, F0h returns to read mode. 90h followed by 00h also returns to read mode. Any other write is ignored. After 90h, a byte other than 00h or F0h returns to verify mode.
- R10: rdata_valid_o pulses exactly in the cycle after each rd_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| elevated_i | input | 1 | Digital stand-in for the elevated reset level |
| wr_valid_i | input | 1 | Qualified write strobe |
| rd_valid_i | input | 1 | Read strobe |
| addr_i | input | AW | Byte address of the write or read |
| wdata_i | input | 8 | Command or data byte |
| rdata_o | output | 8 | Read data, valid with rdata_valid_o |
| rdata_valid_o | output | 1 | Read data valid, one cycle after rd_valid_i |
| locked_o | output | 1 | Sticky lock bit |
| prot_mode_o | output | 1 | High whenever the machine is outside read mode |
| sec_we_o | output | 1 | Write enable toward region storage |

## Verification
The properties assume that a write strobe and a read strobe never fall in the same cycle, and that addr_i and wdata_i are stable whenever a strobe is high. The stimulus tasks drive at most one strobe per cycle on the falling edge and hold address and data for the whole cycle. The assertion on a rising lock takes for granted that the lock is only ever set by an accepted write. The bench therefore never toggles rst_ni after the first release, so that assertion and the sticky-lock property see a single reset episode.

// File: rtl/seclock_pkg.sv
package seclock_pkg;
  typedef enum logic [2:0] {
    ST_READ,
    ST_SETTLE,
    ST_WAIT_SETUP,
    ST_WAIT_LOCK,
    ST_VERIFY,
    ST_EXIT_ARM
  } sq_state_e;

  localparam logic [7:0] CMD_SETUP  = 8'h60;
  localparam logic [7:0] CMD_LOCK   = 8'h40;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_EXIT_A = 8'h90;
  localparam logic [7:0] CMD_EXIT_B = 8'h00;
endpackage

// File: rtl/seclock_decode.sv
module seclock_decode #(
  parameter int          AW       = 21,
  parameter int          SEC_LG   = 8,
  parameter logic [AW-1:0] SEC_BASE = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          in_region_o,
  output logic          is_status_o
);
  localparam int HI_W = AW - SEC_LG;
  localparam logic [HI_W-1:0] BASE_HI = SEC_BASE[AW-1:SEC_LG];

  always_comb begin
    in_region_o = (addr_i[AW-1:SEC_LG] == BASE_HI);
    // status pattern: a6=0, a1=1, a0=0
    is_status_o = in_region_o && !addr_i[6] && addr_i[1] && !addr_i[0];
  end
endmodule

// File: rtl/seclock_settle.sv
module seclock_settle #(
  parameter int SETTLE_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/seclock_fsm.sv
module seclock_fsm
  import seclock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       elevated_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wdata_i,
  input  logic       is_status_i,
  input  logic       settle_done_i,
  output sq_state_e  state_o,
  output logic       lock_o
);
  sq_state_e state_q, state_d;
  logic      lock_q, lock_set;

  always_comb begin
    state_d  = state_q;
    lock_set = 1'b0;
    unique case (state_q)
      ST_READ:   if (elevated_i) state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (!elevated_i)        state_d = ST_READ;
        else if (settle_done_i) state_d = ST_WAIT_SETUP;
      end
      ST_WAIT_SETUP: begin
        if (!elevated_i) state_d = ST_READ;
        else if (wr_valid_i)
          state_d = (wdata_i == CMD_SETUP) ? ST_WAIT_LOCK : ST_READ;
      end
      ST_WAIT_LOCK: begin
        if (!elevated_i) state_d = ST_READ;
        else if (wr_valid_i) begin
          if (wdata_i == CMD_LOCK && is_status_i) begin
            state_d  = ST_VERIFY;
            lock_set = 1'b1;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_VERIFY: begin
        if (wr_valid_i) begin
          if (wdata_i == CMD_RESET)       state_d = ST_READ;
          else if (wdata_i == CMD_EXIT_A) state_d = ST_EXIT_ARM;
        end
      end
      ST_EXIT_ARM: begin
        if (wr_valid_i)
          state_d = (wdata_i == CMD_EXIT_B || wdata_i == CMD_RESET) ? ST_READ : ST_VERIFY;
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (lock_set) lock_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign lock_o  = lock_q;
endmodule

// File: rtl/seclock_seq.sv
module seclock_seq
  import seclock_pkg::*;
#(
  parameter int            AW         = 21,
  parameter int            SEC_LG     = 8,
  parameter logic [AW-1:0] SEC_BASE   = '0,
  parameter int            SETTLE_CYC = 250
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          elevated_i,
  input  logic          wr_valid_i,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          rdata_valid_o,
  output logic          locked_o,
  output logic          prot_mode_o,
  output logic          sec_we_o
);
  logic      in_region, is_status, settle_done, lock;
  sq_state_e state;
  logic      stat_window;
  logic [7:0] rdata_q;
  logic       rvalid_q;

  seclock_decode #(.AW(AW), .SEC_LG(SEC_LG), .SEC_BASE(SEC_BASE)) u_dec (
    .addr_i      (addr_i),
    .in_region_o (in_region),
    .is_status_o (is_status)
  );

  seclock_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_SETTLE && elevated_i),
    .done_o (settle_done)
  );

  seclock_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .elevated_i    (elevated_i),
    .wr_valid_i    (wr_valid_i),
    .wdata_i       (wdata_i),
    .is_status_i   (is_status),
    .settle_done_i (settle_done),
    .state_o       (state),
    .lock_o        (lock)
  );

  assign stat_window = (state == ST_WAIT_LOCK) || (state == ST_VERIFY) || (state == ST_EXIT_ARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_valid_i;
      rdata_q  <= (rd_valid_i && stat_window && is_status) ? {7'b0, lock} : 8'h00;
    end
  end

  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
  assign locked_o      = lock;
  assign prot_mode_o   = (state != ST_READ);
  assign sec_we_o      = wr_valid_i && in_region && !lock && (state == ST_READ);
endmodule

// File: rtl/seclock_chk.sv
module seclock_chk #(
  parameter int            AW       = 21,
  parameter int            SEC_LG   = 8,
  parameter logic [AW-1:0] SEC_BASE = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          rd_valid_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          rdata_valid_o,
  input logic          locked_o,
  input logic          sec_we_o
);
  logic stat_addr;
  assign stat_addr = (addr_i[AW-1:SEC_LG] == SEC_BASE[AW-1:SEC_LG]) &&
                     !addr_i[6] && addr_i[1] && !addr_i[0];

  // R7
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(locked_o));

  // R3
  lock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(wr_valid_i && wdata_i == 8'h40 && stat_addr));

  // R8
  no_locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !sec_we_o);

  // R10
  read_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rdata_valid_o);

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !rdata_valid_o);

  // R4
  status_only_when_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_valid_o && rdata_o != 8'h00) |-> (locked_o && rdata_o == 8'h01));
endmodule

bind seclock_seq seclock_chk #(.AW(AW), .SEC_LG(SEC_LG), .SEC_BASE(SEC_BASE)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_valid_i    (wr_valid_i),
  .rd_valid_i    (rd_valid_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .rdata_valid_o (rdata_valid_o),
  .locked_o      (locked_o),
  .sec_we_o      (sec_we_o)
);

// File: tb/seclock_seq_bench.sv
module seclock_seq_bench;
  localparam int AW = 21;
  localparam int SETTLE = 20;
  localparam logic [AW-1:0] A_STAT = 21'h000002;
  localparam logic [AW-1:0] A_BADB = 21'h000042;
  localparam logic [AW-1:0] A_OUT  = 21'h100002;
  localparam logic [AW-1:0] A_REG  = 21'h000010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic elev = 1'b0, wv = 1'b0, rv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rvalid, locked, prot, sec_we;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  seclock_seq #(.AW(AW), .SETTLE_CYC(SETTLE)) u_seclock_seq (
    .clk_i(clk), .rst_ni(rst_n), .elevated_i(elev), .wr_valid_i(wv),
    .rd_valid_i(rv), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rdata_valid_o(rvalid), .locked_o(locked), .prot_mode_o(prot), .sec_we_o(sec_we)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wv = 1'b1;
    @(negedge clk); wv = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e);
    @(negedge clk); addr = a; rv = 1'b1; exp_q.push_back(e);
    @(negedge clk); rv = 1'b0;
  endtask

  task automatic enter_and_settle();
    @(negedge clk); elev = 1'b1;
    repeat (SETTLE + 3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected valid", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rdata == e, "R4 read data", rdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(locked == 1'b0, "R1 locked", locked, 0);
    chk(prot == 1'b0, "R1 prot", prot, 0);
    chk(rvalid == 1'b0, "R1 valid", rvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 unlocked region write passes
    addr = A_REG; wdata = 8'hA5; wv = 1'b1; #1;
    chk(sec_we == 1'b1, "R8 unlocked write", sec_we, 1);
    @(negedge clk); wv = 1'b0;
    rd(A_STAT, 8'h00);  // R4 read mode
    rd(A_REG, 8'h00);

    // R2 settle ignores writes; premature 40h finds no setup
    @(negedge clk); elev = 1'b1;
    @(negedge clk);
    chk(prot == 1'b1, "R2 settle entered", prot, 1);
    wr(A_STAT, 8'h60);
    repeat (SETTLE + 2) @(negedge clk);
    wr(A_STAT, 8'h40);
    chk(prot == 1'b0, "R2 write during settle ignored", prot, 0);
    chk(locked == 1'b0, "R2 no lock", locked, 0);
    elev = 1'b0;
    @(negedge clk);

    // R5 wrong byte after setup
    enter_and_settle();
    wr(21'h0ABCDE, 8'h60);
    chk(prot == 1'b1, "R3 setup accepted", prot, 1);
    wr(A_STAT, 8'h55);
    chk(prot == 1'b0 && locked == 1'b0, "R5 wrong data", {prot, locked}, 0);
    elev = 1'b0; @(negedge clk);

    // R5 40h at wrong addresses
    enter_and_settle();
    wr(A_STAT, 8'h60);
    wr(A_BADB, 8'h40);
    chk(prot == 1'b0 && locked == 1'b0, "R5 bit6 set", {prot, locked}, 0);
    elev = 1'b0; @(negedge clk);
    enter_and_settle();
    wr(A_STAT, 8'h60);
    wr(A_OUT, 8'h40);
    chk(prot == 1'b0 && locked == 1'b0, "R5 outside region", {prot, locked}, 0);
    elev = 1'b0; @(negedge clk);

    // R4 unlocked status, R6 abort by deassert
    enter_and_settle();
    wr(A_STAT, 8'h60);
    rd(A_STAT, 8'h00);
    elev = 1'b0;
    @(negedge clk);
    chk(prot == 1'b0, "R6 abort on deassert", prot, 0);

    // R3 lock
    enter_and_settle();
    wr(21'h012345, 8'h60);
    @(negedge clk); addr = A_STAT; wdata = 8'h40; wv = 1'b1; #1;
    chk(locked == 1'b0, "R3 not yet locked", locked, 0);
    @(negedge clk); wv = 1'b0;
    chk(locked == 1'b1, "R3 locked next clock", locked, 1);
    rd(A_STAT, 8'h01);  // R4 locked status
    rd(A_BADB, 8'h00);
    // R9 stray write ignored, deassert ignored
    wr(A_STAT, 8'h55);
    elev = 1'b0;
    @(negedge clk);
    chk(prot == 1'b1, "R9 stay in verify", prot, 1);
    wr(A_STAT, 8'h90);
    wr(A_STAT, 8'h33);
    chk(prot == 1'b1, "R9 broken exit pair", prot, 1);
    rd(A_STAT, 8'h01);
    wr(A_STAT, 8'h90);
    wr(A_STAT, 8'h00);
    chk(prot == 1'b0, "R9 exit pair", prot, 0);
    chk(locked == 1'b1, "R7 sticky after exit", locked, 1);

    // R8 locked region write blocked
    @(negedge clk); addr = A_REG; wdata = 8'h11; wv = 1'b1; #1;
    chk(sec_we == 1'b0, "R8 locked write", sec_we, 0);
    @(negedge clk); wv = 1'b0;

    // R9 reset command, R7 sticky
    enter_and_settle();
    wr(A_STAT, 8'h60);
    wr(A_STAT, 8'h40);
    wr(A_STAT, 8'hF0);
    chk(prot == 1'b0, "R9 reset cmd", prot, 0);
    chk(locked == 1'b1, "R7 sticky after reset cmd", locked, 1);
    @(negedge clk);
    chk(rvalid == 1'b0, "R10 idle valid", rvalid, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule